// File: doc/BRIEF.md
# Vectored Prioritised Interrupt Controller

The block gathers 64 interrupt request lines and presents one request line to a processor. Each source has its own setup word that chooses level or edge sensitivity and a 3-bit priority level. Per-source enables are changed through write-one-to-set and write-one-to-clear words, and each kind has one word for sources 0..31 and one for sources 32..63. A global enable bit gates the request line.

The processor reads a vector word to learn the winning source. That read also records the winner's level as the in-service level. Writing the end-of-service word drops the in-service level, so lower and equal levels can request again. An edge source's latched flag is acknowledged by rewriting its setup word. A soft reset word returns every register to zero. Access is through a simple byte-addressed 32-bit register port. Read data appears one cycle after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset `irq_out` is 0, all enables are 0 and the vector word (0x008) reads 64.
- R2: Writing the set words (0x040 for sources 0..31, 0x044 for 32..63) sets the enable of each source whose bit is 1. Bits written as 0 change nothing. The enables read back at 0x080 and 0x084.
- R3: Writing the clear words (0x060 low, 0x064 high) clears the enable of each source whose bit is 1. Bits written as 0 change nothing.
- R4: Source n has a setup word at 0x200 + 8*n. Bits [2:0] hold the level and bit 4 selects edge mode (1) or level mode (0). A read returns only these bits, and the other bits read as 0.
- R5: A level-mode source is pending while its input is high. `irq_out` rises in the cycle after the input is sampled high and falls in the cycle after it is sampled low.
- R6: An edge-mode source latches a flag on a rising input, and the flag stays after the input drops. Any write to that source's setup word clears the flag. A rising edge sampled in the same cycle as that write is kept.
- R7: The vector word returns the enabled, pending source with the highest non-zero level above the in-service level. Among sources of equal level, the lower number wins. It returns 64 when no source qualifies. Level 0 and disabled sources never win.
- R8: Bit 0 of the control word (0x000) is the global enable. `irq_out` is 0 while it is clear, and the vector word is unaffected by it.
- R9: A vector read that returns a source 0..63 makes that source's level the in-service level. Until any write to 0x00C, sources at or below that level neither drive `irq_out` nor win the vector, while higher levels still do.
- R10: Writing 0x004 with bit 0 set clears all enables, setup words, edge flags, the in-service level and the global enable. With bit 0 clear the write has no effect.
- R11: `bus_rdata` is 0 except in the cycle after a read of a readable word. Write-only and unmapped words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Interrupt request lines, synchronous to clk |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_out | output | 1 | Request to the processor |

## Verification
Two functions can fall in the same cycle: an edge source sees a new rising input in the cycle in which software acknowledges it by rewriting its setup word. The bench raises the input and issues the setup write on the same edge. It then requires `irq_out` to remain high, because the new edge must survive the acknowledge. A second acknowledge with the input low must drop the request.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Register offsets (byte addresses)
    localparam int OFF_CTRL     = 'h000;
    localparam int OFF_RESET    = 'h004;
    localparam int OFF_VECTOR   = 'h008;
    localparam int OFF_EOI      = 'h00C;
    localparam int OFF_EN_SET   = 'h040;
    localparam int OFF_EN_CLR   = 'h060;
    localparam int OFF_EN_STAT  = 'h080;
    localparam int OFF_SETUP    = 'h200;
    localparam int SETUP_STRIDE = 8;
    // Setup word layout
    localparam int EDGE_BIT     = 4;
    localparam int BANK_W       = 32;
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] ack,
    input  logic            clr_all,
    output logic [NSRC-1:0] in_q,
    output logic [NSRC-1:0] flag_q
);
    typedef struct packed {
        logic [NSRC-1:0] smp;
        logic [NSRC-1:0] flag;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        logic [NSRC-1:0] rise;
        rise       = irq_in & ~lat_q.smp;
        lat_d.smp  = irq_in;
        // A new edge outranks an acknowledge in the same cycle
        lat_d.flag = (lat_q.flag & ~ack) | (rise & edge_sel);
        if (clr_all) begin
            lat_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign in_q   = lat_q.smp;
    assign flag_q = lat_q.flag;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NSRC  = 64,
    parameter int LVL_W = 3
) (
    input  logic [NSRC-1:0]            cand,
    input  logic [NSRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]           floor_lvl,
    output logic                       win_valid,
    output logic [$clog2(NSRC)-1:0]    win_idx,
    output logic [LVL_W-1:0]           win_lvl
);
    localparam int IDX_W = $clog2(NSRC);

    always_comb begin
        logic [LVL_W-1:0] best;
        best      = floor_lvl;
        win_valid = 1'b0;
        win_idx   = '0;
        // Strictly greater keeps the lowest index on a tie
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (lvl[i] > best)) begin
                best      = lvl[i];
                win_idx   = IDX_W'(i);
                win_valid = 1'b1;
            end
        end
        win_lvl = best;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NSRC   = 64,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    import vic_pkg::*;

    localparam int NBANK  = NSRC / BANK_W;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int SPAN   = NSRC * SETUP_STRIDE;
    localparam int SHIFT  = $clog2(SETUP_STRIDE);

    typedef struct packed {
        logic                       gen_en;
        logic [NSRC-1:0]            en;
        logic [NSRC-1:0][LVL_W-1:0] lvl;
        logic [NSRC-1:0]            edge_sel;
        logic [LVL_W-1:0]           cur_lvl;
        logic [31:0]                rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0]   in_q;
    logic [NSRC-1:0]   flag_q;
    logic [NSRC-1:0]   ack;
    logic              clr_all;
    logic [NSRC-1:0]   cand;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [LVL_W-1:0]  win_lvl;

    vic_edge_latch #(.NSRC(NSRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .edge_sel (st_q.edge_sel),
        .ack      (ack),
        .clr_all  (clr_all),
        .in_q     (in_q),
        .flag_q   (flag_q)
    );

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            cand[i] = st_q.en[i] && (st_q.edge_sel[i] ? flag_q[i] : in_q[i]);
        end
    end

    vic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
        .cand      (cand),
        .lvl       (st_q.lvl),
        .floor_lvl (st_q.cur_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    always_comb begin
        logic [ADDR_W-1:0] soff;
        logic [IDX_W-1:0]  sidx;
        logic              is_setup;

        soff     = bus_addr - ADDR_W'(OFF_SETUP);
        sidx     = soff[SHIFT +: IDX_W];
        is_setup = (bus_addr >= ADDR_W'(OFF_SETUP)) && (soff < ADDR_W'(SPAN))
                   && (soff[SHIFT-1:0] == '0);

        st_d       = st_q;
        st_d.rdata = '0;
        ack        = '0;
        clr_all    = 1'b0;

        // Read path: always from the pre-write state
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                st_d.rdata = {31'd0, st_q.gen_en};
            end else if (bus_addr == ADDR_W'(OFF_VECTOR)) begin
                st_d.rdata = win_valid ? 32'(win_idx) : 32'(NSRC);
            end else if (is_setup) begin
                st_d.rdata = 32'(st_q.lvl[sidx])
                           | (32'(st_q.edge_sel[sidx]) << EDGE_BIT);
            end
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == ADDR_W'(OFF_EN_STAT + 4 * b)) begin
                    st_d.rdata = st_q.en[b*BANK_W +: BANK_W];
                end
            end
        end

        // Write path
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                st_d.gen_en = bus_wdata[0];
            end
            if (bus_addr == ADDR_W'(OFF_EOI)) begin
                st_d.cur_lvl = '0;
            end
            if (is_setup) begin
                st_d.lvl[sidx]      = bus_wdata[LVL_W-1:0];
                st_d.edge_sel[sidx] = bus_wdata[EDGE_BIT];
                ack[sidx]           = 1'b1;
            end
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == ADDR_W'(OFF_EN_SET + 4 * b)) begin
                    st_d.en[b*BANK_W +: BANK_W] = st_q.en[b*BANK_W +: BANK_W] | bus_wdata;
                end
                if (bus_addr == ADDR_W'(OFF_EN_CLR + 4 * b)) begin
                    st_d.en[b*BANK_W +: BANK_W] = st_q.en[b*BANK_W +: BANK_W] & ~bus_wdata;
                end
            end
        end

        // Vector claim raises the in-service level
        if (bus_rd && (bus_addr == ADDR_W'(OFF_VECTOR)) && win_valid) begin
            st_d.cur_lvl = win_lvl;
        end

        // Soft reset overrides everything
        if (bus_wr && (bus_addr == ADDR_W'(OFF_RESET)) && bus_wdata[0]) begin
            st_d    = '0;
            clr_all = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_out   = st_q.gen_en & win_valid;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NSRC   = 64,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic [NSRC-1:0]   en_q,
    input logic [LVL_W-1:0]  cur_lvl_q,
    input logic              win_valid,
    input logic [LVL_W-1:0]  win_lvl
);
    import vic_pkg::*;

    logic srst;
    assign srst = bus_wr && (bus_addr == ADDR_W'(OFF_RESET)) && bus_wdata[0];

    // R2: set word ORs into the low bank
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_SET))
        |=> en_q[31:0] == ($past(en_q[31:0]) | $past(bus_wdata)));

    // R3: clear word removes bits from the low bank
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_CLR))
        |=> en_q[31:0] == ($past(en_q[31:0]) & ~$past(bus_wdata)));

    // R7: a winner is always above the in-service level
    assert_win_above_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_lvl > cur_lvl_q));

    // R7: empty vector reads as NSRC
    assert_vec_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_VECTOR) && !win_valid && !srst)
        |=> bus_rdata == 32'(NSRC));

    // R8: clearing the global enable silences the output
    assert_gen_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[0]) |=> !irq_out);

    // R9: a claiming vector read records the winner level
    assert_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_VECTOR) && win_valid && !srst)
        |=> cur_lvl_q == $past(win_lvl));

    // R10: soft reset clears output and enables
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq_out && en_q == '0 && cur_lvl_q == '0));

    // R11: no read, no data
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0);
endmodule

bind vic_top vic_checker #(.NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_q      (st_q.en),
    .cur_lvl_q (st_q.cur_lvl),
    .win_valid (win_valid),
    .win_lvl   (win_lvl)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    vic_top dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_expect(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s irq_out act=%b exp=%b", t, irq_out, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check_irq(1'b0, "R1 irq after reset");
        read_expect(12'h008, 32'd64, "R1 vector after reset");
        read_expect(12'h080, 32'h0, "R1 enables after reset");

        // R2 set banks
        bus_write(12'h040, 32'h0000_00F0);
        read_expect(12'h080, 32'h0000_00F0, "R2 set low");
        bus_write(12'h040, 32'h0000_0003);
        read_expect(12'h080, 32'h0000_00F3, "R2 zero bits keep");
        bus_write(12'h044, 32'h8000_0001);
        read_expect(12'h084, 32'h8000_0001, "R2 set high");

        // R3 clear banks
        bus_write(12'h060, 32'h0000_0030);
        read_expect(12'h080, 32'h0000_00C3, "R3 clear low");
        bus_write(12'h064, 32'h0000_0001);
        read_expect(12'h084, 32'h8000_0000, "R3 clear high");

        // R4 setup words
        bus_write(12'h230, 32'h5);
        read_expect(12'h230, 32'h5, "R4 setup src6");
        bus_write(12'h3F8, 32'h13);
        read_expect(12'h3F8, 32'h13, "R4 setup src63 edge");
        bus_write(12'h208, 32'hFFFF_FFFF);
        read_expect(12'h208, 32'h17, "R4 unused bits read zero");
        bus_write(12'h208, 32'h0);

        // R8 / R5 level source with global enable
        irq_in[6] = 1'b1;
        idle(2);
        check_irq(1'b0, "R8 gen off blocks request");
        bus_write(12'h000, 32'h1);
        check_irq(1'b1, "R5 level source requests");
        read_expect(12'h000, 32'h1, "R8 control readback");
        irq_in[6] = 1'b0;
        idle(1);
        check_irq(1'b0, "R5 level drop follows input");
        irq_in[6] = 1'b1;
        bus_write(12'h000, 32'h0);
        read_expect(12'h008, 32'd6, "R8 vector ignores gen");
        bus_write(12'h00C, 32'h0);
        bus_write(12'h000, 32'h1);
        irq_in[6] = 1'b0;
        idle(1);
        check_irq(1'b0, "R5 idle after drop");

        // R6 edge latching and acknowledge
        irq_in[63] = 1'b1;
        idle(1);
        irq_in[63] = 1'b0;
        idle(1);
        check_irq(1'b1, "R6 edge latched after input drop");
        bus_write(12'h3F8, 32'h13);
        check_irq(1'b0, "R6 setup write clears flag");
        @(negedge clk);
        irq_in[63] = 1'b1;
        bus_addr = 12'h3F8; bus_wdata = 32'h13; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check_irq(1'b1, "R6 edge kept over same-cycle ack");
        irq_in[63] = 1'b0;
        bus_write(12'h3F8, 32'h13);
        check_irq(1'b0, "R6 second ack clears");

        // R7 priority and R9 in-service
        bus_write(12'h200, 32'h2);
        bus_write(12'h238, 32'h5);
        irq_in[0] = 1'b1; irq_in[1] = 1'b1; irq_in[6] = 1'b1; irq_in[7] = 1'b1;
        idle(1);
        check_irq(1'b1, "R5 several levels pending");
        read_expect(12'h008, 32'd6, "R7 tie goes to lower index");
        check_irq(1'b0, "R9 same level masked in service");
        read_expect(12'h008, 32'd64, "R9 vector empty in service");
        irq_in[63] = 1'b1;
        idle(1);
        irq_in[63] = 1'b0;
        idle(1);
        check_irq(1'b0, "R9 lower edge masked in service");
        bus_write(12'h00C, 32'h0);
        check_irq(1'b1, "R9 eoi reopens");
        read_expect(12'h008, 32'd6, "R7 winner after eoi");
        bus_write(12'h00C, 32'h0);
        irq_in[6] = 1'b0; irq_in[7] = 1'b0;
        idle(1);
        read_expect(12'h008, 32'd63, "R7 level 3 over level 2");
        check_irq(1'b0, "R9 level 2 below service 3");
        bus_write(12'h228, 32'h7);
        irq_in[5] = 1'b1;
        idle(1);
        check_irq(1'b0, "R7 disabled source ignored");
        bus_write(12'h040, 32'h20);
        check_irq(1'b1, "R9 higher level breaks through");
        bus_write(12'h060, 32'h20);
        bus_write(12'h00C, 32'h0);
        bus_write(12'h3F8, 32'h13);
        irq_in[0] = 1'b0;
        idle(1);
        read_expect(12'h008, 32'd64, "R7 level 0 never wins");
        check_irq(1'b0, "R7 level 0 no request");

        // R11 unreadable words
        read_expect(12'h0FC, 32'h0, "R11 unmapped reads zero");
        read_expect(12'h00C, 32'h0, "R11 eoi reads zero");
        read_expect(12'h040, 32'h0, "R11 set word reads zero");

        // R10 soft reset
        bus_write(12'h004, 32'h0);
        read_expect(12'h080, 32'h0000_00C3, "R10 bit0 clear no effect");
        bus_write(12'h004, 32'h1);
        read_expect(12'h080, 32'h0, "R10 enables cleared");
        read_expect(12'h230, 32'h0, "R10 setup cleared");
        read_expect(12'h000, 32'h0, "R10 gen cleared");
        check_irq(1'b0, "R10 no request after reset");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard residue act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule